// File: doc/BRIEF.md
# Accumulator Machine Execution Core

This block is a multicycle processor core for a 16-bit, accumulator-only instruction set. It holds three 16-bit architectural registers: the accumulator, the program counter and the instruction register. The program counter only ever uses its low 12 bits. A 4096-word by 16-bit memory sits inside the block and holds both code and data. Every instruction word splits into a 4-bit operation code in bits 15:12 and a 12-bit address in bits 11:0. The core steps through fetch, decode and execute for each instruction. It hands I/O and shift instructions to external sub-units over a request/done handshake.

The state machine has six named states. FETCH presents the program counter to memory. DECODE captures the fetched word into the instruction register and starts the operand read at its address field. EXECUTE applies the operation. IO_WAIT holds an I/O request, SHIFT_WAIT holds a shift request, and HALTED is terminal.

The transitions are:
- FETCH to DECODE, always.
- DECODE to EXECUTE, always.
- EXECUTE to FETCH for every memory, logic and jump operation.
- EXECUTE to IO_WAIT on operation 1.
- EXECUTE to SHIFT_WAIT on operation 2.
- EXECUTE to HALTED on operation 0.
- IO_WAIT to FETCH on `io_done`.
- SHIFT_WAIT to FETCH on `sh_done`.
- HALTED to HALTED until reset.

A preload port writes memory directly so that a test environment can place a program before releasing reset.

Top module: `acc_core`

## Requirements
- R1: After reset the program counter and accumulator are 0, and `halted`, `io_req` and `sh_req` are all low.
- R2: Each instruction other than I/O and shift uses exactly three clock cycles (FETCH, DECODE, EXECUTE). After any non-jump instruction the program counter advances by one modulo 4096, so 0xFFF is followed by 0x000.
- R3: The following operation codes update the accumulator. `load` (3) sets it to mem[addr]. `add` (5) and `sub` (6) wrap modulo 2^16. `and` (7), `or` (8) and `xor` (9) combine it with mem[addr]. `not` (A) inverts every bit. `store` (4) writes the accumulator to mem[addr].
- R4: `nop` (B) leaves the accumulator and memory unchanged.
- R5: `jmp` (C) always loads the address field into the program counter. `jmpe` (D) does so only when the accumulator is zero. `jmpl` (E) does so only when accumulator bit 15 is set. An untaken jump advances by one.
- R6: `brl` (F) sets the accumulator to the zero-extended 12-bit value (PC+1) mod 4096 and loads the program counter with the address field.
- R7: Operation code 0 halts, and bits 11:0 of that word are ignored. `halted` then stays high, and the program counter (left at the halting word's address) and the accumulator stay frozen until reset.
- R8: Instruction fetch always reads the current memory contents, so a word written by `store` executes in its new form the next time it is fetched.
- R9: Operation code 1 raises `io_req` with `io_op` equal to instruction bits 11:10. `io_req` and `io_op` are held until `io_done`. On `io_done`, codes 00 and 01 load the accumulator from `io_rdata` and codes 10 and 11 leave it unchanged. `acc_o` carries the accumulator during the request.
- R10: Operation code 2 raises `sh_req` with `sh_op` equal to bits 11:10 and `sh_count` equal to bits 3:0. Both are held until `sh_done`, which loads the accumulator from `sh_result`.
- R11: `io_req` and `sh_req` are never high together, and neither is high outside its own instruction.
- R12: While `preload_en` is high, `preload_data` is written to memory word `preload_addr` on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preload_en | input | 1 | Memory preload write strobe |
| preload_addr | input | 12 | Preload word address |
| preload_data | input | 16 | Preload word value |
| io_req | output | 1 | I/O sub-unit request |
| io_op | output | 2 | I/O kind (instruction bits 11:10) |
| io_done | input | 1 | I/O sub-unit completion |
| io_rdata | input | 16 | Value returned by an input operation |
| sh_req | output | 1 | Shift sub-unit request |
| sh_op | output | 2 | Shift kind (instruction bits 11:10) |
| sh_count | output | 4 | Shift distance (instruction bits 3:0) |
| sh_done | input | 1 | Shift sub-unit completion |
| sh_result | input | 16 | Shifted accumulator value |
| acc_o | output | 16 | Accumulator value |
| pc_o | output | 12 | Program counter value |
| halted | output | 1 | High once a halt word has executed |

## Verification
The bench targets the following corner cases:
- A halt word with non-zero low bits. A decoder that looks past the operation code would run on instead of halting.
- A store that overwrites a word which is fetched later. A core that caches or prefetches instructions would execute the stale word and end with a different accumulator.
- Both the taken and untaken forms of the zero and negative jumps, with the negative test driven by bit 15 alone.
- Add and sub results that cross 2^16, where any flag or widened arithmetic would corrupt the accumulator.
- A program-counter step from 0xFFF to 0x000.
- Output I/O operations, which must not write the returned data into the accumulator, and a request that is held several cycles before completion.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        OP_HALT  = 4'h0,
        OP_IO    = 4'h1,
        OP_SHIFT = 4'h2,
        OP_LOAD  = 4'h3,
        OP_STORE = 4'h4,
        OP_ADD   = 4'h5,
        OP_SUB   = 4'h6,
        OP_AND   = 4'h7,
        OP_OR    = 4'h8,
        OP_XOR   = 4'h9,
        OP_NOT   = 4'hA,
        OP_NOP   = 4'hB,
        OP_JMP   = 4'hC,
        OP_JMPZ  = 4'hD,
        OP_JMPN  = 4'hE,
        OP_BRL   = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_IO_WAIT,
        ST_SHIFT_WAIT,
        ST_HALTED
    } core_state_e;

    typedef enum logic [1:0] {
        PC_KEEP,
        PC_INC,
        PC_TARGET
    } pc_sel_e;

    typedef enum logic [1:0] {
        ACC_FROM_ALU,
        ACC_FROM_IO,
        ACC_FROM_SHIFT
    } acc_src_e;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr] <= wdata;
        end
        rdata <= words_q[raddr];
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] link,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        case (op)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_AND:  result = acc & operand;
            OP_OR:   result = acc | operand;
            OP_XOR:  result = acc ^ operand;
            OP_NOT:  result = ~acc;
            OP_BRL:  result = link;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  opcode_e     exec_op,
    input  logic        acc_zero,
    input  logic        acc_neg,
    input  logic        io_is_read,
    input  logic        io_done,
    input  logic        sh_done,
    output core_state_e state_o,
    output logic        ir_load,
    output logic        acc_load,
    output acc_src_e    acc_src,
    output pc_sel_e     pc_sel,
    output logic        mem_we,
    output logic        io_req,
    output logic        sh_req,
    output logic        halted
);
    core_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                if (exec_op == OP_HALT) begin
                    state_d = ST_HALTED;
                end else if (exec_op == OP_IO) begin
                    state_d = ST_IO_WAIT;
                end else if (exec_op == OP_SHIFT) begin
                    state_d = ST_SHIFT_WAIT;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_IO_WAIT:    if (io_done) state_d = ST_FETCH;
            ST_SHIFT_WAIT: if (sh_done) state_d = ST_FETCH;
            ST_HALTED:     state_d = ST_HALTED;
            default:       state_d = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        ir_load  = 1'b0;
        acc_load = 1'b0;
        acc_src  = ACC_FROM_ALU;
        pc_sel   = PC_KEEP;
        mem_we   = 1'b0;
        io_req   = 1'b0;
        sh_req   = 1'b0;
        halted   = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
            end
            ST_DECODE: ir_load = 1'b1;
            ST_EXEC: begin
                unique case (exec_op)
                    OP_HALT, OP_IO, OP_SHIFT: pc_sel = PC_KEEP;
                    OP_LOAD, OP_ADD, OP_SUB, OP_AND,
                    OP_OR, OP_XOR, OP_NOT: begin
                        acc_load = 1'b1;
                        pc_sel   = PC_INC;
                    end
                    OP_STORE: begin
                        mem_we = 1'b1;
                        pc_sel = PC_INC;
                    end
                    OP_NOP:  pc_sel = PC_INC;
                    OP_JMP:  pc_sel = PC_TARGET;
                    OP_JMPZ: pc_sel = acc_zero ? PC_TARGET : PC_INC;
                    OP_JMPN: pc_sel = acc_neg ? PC_TARGET : PC_INC;
                    OP_BRL: begin
                        acc_load = 1'b1;
                        pc_sel   = PC_TARGET;
                    end
                endcase
            end
            ST_IO_WAIT: begin
                io_req = 1'b1;
                if (io_done) begin
                    acc_load = io_is_read;
                    acc_src  = ACC_FROM_IO;
                    pc_sel   = PC_INC;
                end
            end
            ST_SHIFT_WAIT: begin
                sh_req = 1'b1;
                if (sh_done) begin
                    acc_load = 1'b1;
                    acc_src  = ACC_FROM_SHIFT;
                    pc_sel   = PC_INC;
                end
            end
            ST_HALTED: halted = 1'b1;
            default: begin
            end
        endcase
    end

    assign state_o = state_q;

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R2
    AST_HALT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED) |=> (state_q == ST_HALTED)); // R7
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preload_en,
    input  logic [ADDR_W-1:0] preload_addr,
    input  logic [DATA_W-1:0] preload_data,
    output logic              io_req,
    output logic [1:0]        io_op,
    input  logic              io_done,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              sh_req,
    output logic [1:0]        sh_op,
    output logic [3:0]        sh_count,
    input  logic              sh_done,
    input  logic [DATA_W-1:0] sh_result,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              halted
);
    localparam int OPC_W   = 4;
    localparam int OPC_LSB = DATA_W - OPC_W;
    localparam int CNT_W   = 4;
    localparam int EXT_W   = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    logic [DATA_W-1:0] acc_q, ir_q, mem_rdata, alu_result, acc_d, link;
    logic [ADDR_W-1:0] pc_q, mem_raddr, mem_waddr, pc_plus;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we_all, core_we, ir_load, acc_load;
    opcode_e           exec_op;
    core_state_e       state;
    pc_sel_e           pc_sel;
    acc_src_e          acc_src;

    assign exec_op = opcode_e'(ir_q[DATA_W-1:OPC_LSB]);
    assign pc_plus = pc_q + PC_ONE;
    assign link    = {{EXT_W{1'b0}}, pc_plus};

    acc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_op    (exec_op),
        .acc_zero   (acc_q == '0),
        .acc_neg    (acc_q[DATA_W-1]),
        .io_is_read (~ir_q[ADDR_W-1]),
        .io_done    (io_done),
        .sh_done    (sh_done),
        .state_o    (state),
        .ir_load    (ir_load),
        .acc_load   (acc_load),
        .acc_src    (acc_src),
        .pc_sel     (pc_sel),
        .mem_we     (core_we),
        .io_req     (io_req),
        .sh_req     (sh_req),
        .halted     (halted)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (exec_op),
        .acc     (acc_q),
        .operand (mem_rdata),
        .link    (link),
        .result  (alu_result)
    );

    // read address: PC on fetch, fresh address field on decode
    always_comb begin
        unique case (state)
            ST_FETCH:  mem_raddr = pc_q;
            ST_DECODE: mem_raddr = mem_rdata[ADDR_W-1:0];
            default:   mem_raddr = ir_q[ADDR_W-1:0];
        endcase
    end

    assign mem_we_all = preload_en | core_we;
    assign mem_waddr  = preload_en ? preload_addr : ir_q[ADDR_W-1:0];
    assign mem_wdata  = preload_en ? preload_data : acc_q;

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we_all),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        unique case (acc_src)
            ACC_FROM_IO:    acc_d = io_rdata;
            ACC_FROM_SHIFT: acc_d = sh_result;
            default:        acc_d = alu_result;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            pc_q  <= '0;
            ir_q  <= '0;
        end else begin
            if (ir_load) ir_q <= mem_rdata;
            if (acc_load) acc_q <= acc_d;
            unique case (pc_sel)
                PC_INC:    pc_q <= pc_plus;
                PC_TARGET: pc_q <= ir_q[ADDR_W-1:0];
                default:   pc_q <= pc_q;
            endcase
        end
    end

    assign io_op    = ir_q[ADDR_W-1:ADDR_W-2];
    assign sh_op    = ir_q[ADDR_W-1:ADDR_W-2];
    assign sh_count = ir_q[CNT_W-1:0];
    assign acc_o    = acc_q;
    assign pc_o     = pc_q;

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_q) && $stable(acc_q))); // R7
    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && exec_op >= OP_LOAD && exec_op <= OP_NOP)
        |=> (pc_q == $past(pc_plus))); // R2
    AST_NOP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && exec_op == OP_NOP) |=> $stable(acc_q)); // R4
    AST_JMPZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && exec_op == OP_JMPZ && acc_q == '0)
        |=> (pc_q == $past(ir_q[ADDR_W-1:0]))); // R5
    AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_done) |=> (io_req && $stable(io_op))); // R9
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && !sh_done) |=> (sh_req && $stable(sh_count))); // R10
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && sh_req)); // R11
endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 4096;
    localparam int RUN_LIMIT  = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        preload_en = 1'b0;
    logic [11:0] preload_addr = '0;
    logic [15:0] preload_data = '0;
    logic        io_req, sh_req, halted;
    logic [1:0]  io_op, sh_op;
    logic [3:0]  sh_count;
    logic        io_done = 1'b0, sh_done = 1'b0;
    logic [15:0] io_rdata = '0, sh_result = '0, acc_o;
    logic [11:0] pc_o;

    acc_core u_acc_core (
        .clk(clk), .rst_n(rst_n),
        .preload_en(preload_en), .preload_addr(preload_addr), .preload_data(preload_data),
        .io_req(io_req), .io_op(io_op), .io_done(io_done), .io_rdata(io_rdata),
        .sh_req(sh_req), .sh_op(sh_op), .sh_count(sh_count),
        .sh_done(sh_done), .sh_result(sh_result),
        .acc_o(acc_o), .pc_o(pc_o), .halted(halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [15:0] mref [WORDS];
    logic [15:0] m_acc, m_ir, printed;
    logic [11:0] m_pc;
    int          m_phase;      // 0 fetch 1 decode 2 exec 3 io 4 shift 5 halted
    logic [15:0] io_q [$];
    int          io_wait;
    int          n_cmp = 0, n_bad = 0;

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [3:0] op);
        case (op)
            4'h0: return "R7";
            4'h1: return "R9";
            4'h2: return "R10";
            4'hB: return "R4";
            4'hC, 4'hD, 4'hE: return "R5";
            4'hF: return "R6";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [15:0] shf(input logic [15:0] v, input logic [1:0] k,
                                        input logic [3:0] n);
        case (k)
            2'b00: return v << n;
            2'b01: return v >> n;
            2'b10: return (v << n) | (v >> (16 - n));
            default: return (v >> n) | (v << (16 - n));
        endcase
    endfunction

    task automatic model_step();
        logic [11:0] a;
        logic [15:0] d;
        a = m_ir[11:0];
        case (m_phase)
            0: m_phase = 1;
            1: begin m_ir = mref[m_pc]; m_phase = 2; end
            2: begin
                a = m_ir[11:0];
                d = mref[a];
                m_phase = 0;
                case (m_ir[15:12])
                    4'h0: m_phase = 5;
                    4'h1: m_phase = 3;
                    4'h2: m_phase = 4;
                    4'h3: begin m_acc = d; m_pc++; end
                    4'h4: begin mref[a] = m_acc; m_pc++; end
                    4'h5: begin m_acc = m_acc + d; m_pc++; end
                    4'h6: begin m_acc = m_acc - d; m_pc++; end
                    4'h7: begin m_acc = m_acc & d; m_pc++; end
                    4'h8: begin m_acc = m_acc | d; m_pc++; end
                    4'h9: begin m_acc = m_acc ^ d; m_pc++; end
                    4'hA: begin m_acc = ~m_acc; m_pc++; end
                    4'hB: m_pc++;
                    4'hC: m_pc = a;
                    4'hD: if (m_acc == 16'h0) m_pc = a; else m_pc++;
                    4'hE: if (m_acc[15]) m_pc = a; else m_pc++;
                    default: begin m_acc = {4'h0, m_pc + 12'h1}; m_pc = a; end
                endcase
            end
            3: if (io_done) begin
                if (!m_ir[11]) m_acc = io_rdata;
                m_pc++;
                m_phase = 0;
            end
            4: if (sh_done) begin m_acc = sh_result; m_pc++; m_phase = 0; end
            default: m_phase = 5;
        endcase
    endtask

    task automatic compare_all();
        string t;
        t = tag_for(m_ir[15:12]);
        check(t, "pc", {4'h0, pc_o}, {4'h0, m_pc});
        check(t, "acc", acc_o, m_acc);
        check("R7", "halted", {15'h0, halted}, {15'h0, m_phase == 5});
        check("R11", "io_req", {15'h0, io_req}, {15'h0, m_phase == 3});
        check("R11", "sh_req", {15'h0, sh_req}, {15'h0, m_phase == 4});
    endtask

    task automatic drive_units();
        io_done = 1'b0;
        sh_done = 1'b0;
        if (io_req) begin
            if (io_wait == 0 && io_op == 2'b10) printed = acc_o;
            io_wait++;
            if (io_wait == 3) begin
                io_done = 1'b1;
                io_wait = 0;
                if (!io_op[1]) io_rdata = io_q.pop_front();
                else io_rdata = 16'hDEAD;
            end
        end
        if (sh_req) begin
            sh_done   = 1'b1;
            sh_result = shf(acc_o, sh_op, sh_count);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < WORDS; i++) mref[i] = 16'hB000;
    endtask

    task automatic run_prog(input int prog, input logic [15:0] exp_acc,
                            input logic [11:0] exp_pc);
        int cyc, extra;
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            preload_en = 1'b1; preload_addr = 12'(i); preload_data = mref[i];
            @(negedge clk);
        end
        preload_en = 1'b0;
        m_pc = '0; m_acc = '0; m_ir = '0; m_phase = 0;
        io_wait = 0; io_done = 1'b0; sh_done = 1'b0;
        @(negedge clk);
        check("R1", "reset pc", {4'h0, pc_o}, 16'h0);
        check("R1", "reset acc", acc_o, 16'h0);
        check("R1", "reset halted", {15'h0, halted}, 16'h0);
        check("R1", "reset reqs", {14'h0, io_req, sh_req}, 16'h0);
        rst_n = 1'b1;
        cyc = 0; extra = 0;
        while (extra < 6 && cyc < RUN_LIMIT) begin
            @(negedge clk);
            cyc++;
            model_step();
            compare_all();
            if (prog == 1 && cyc == 3)
                check("R12", "preloaded operand", acc_o, 16'h3000);
            drive_units();
            if (m_phase == 5) extra++;
        end
        if (cyc >= RUN_LIMIT) check("R7", "run did not halt", 16'h0, 16'h1);
        check("R7", "final halted", {15'h0, halted}, 16'h1);
        check(prog == 1 ? "R3" : "R8", "final acc", acc_o, exp_acc);
        check(prog == 3 ? "R2" : "R5", "final pc", {4'h0, pc_o}, {4'h0, exp_pc});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // program 1: arithmetic/logic chain, r3_ wrap, nop, store/load, halt with low bits
        clear_mem();
        mref[12'h000] = 16'h3010; mref[12'h001] = 16'h5011; mref[12'h002] = 16'h6012;
        mref[12'h003] = 16'h8013; mref[12'h004] = 16'h9014; mref[12'h005] = 16'h7015;
        mref[12'h006] = 16'hA000; mref[12'h007] = 16'h4020; mref[12'h008] = 16'hB000;
        mref[12'h009] = 16'h3020; mref[12'h00A] = 16'h5016; mref[12'h00B] = 16'h6017;
        mref[12'h00C] = 16'h000F;
        mref[12'h010] = 16'h3000; mref[12'h011] = 16'h3000; mref[12'h012] = 16'h5000;
        mref[12'h013] = 16'h8003; mref[12'h014] = 16'h00FF; mref[12'h015] = 16'hF0F0;
        mref[12'h016] = 16'hA000; mref[12'h017] = 16'h1F0F; mref[12'h020] = 16'h0000;
        run_prog(1, 16'hF000, 12'h00C);

        // program 2: jumps taken/untaken (R5), brl link (R6), self-modified halt (R8)
        clear_mem();
        mref[12'h000] = 16'hC005;
        for (int i = 1; i < 5; i++) mref[i] = 16'h0FFF;
        mref[12'h005] = 16'h3030; mref[12'h006] = 16'hD009; mref[12'h007] = 16'h0000;
        mref[12'h009] = 16'hE00C; mref[12'h00A] = 16'h3031; mref[12'h00B] = 16'hD00F;
        mref[12'h00C] = 16'hE00E; mref[12'h00D] = 16'h0000; mref[12'h00E] = 16'hF040;
        mref[12'h00F] = 16'h0000;
        mref[12'h030] = 16'h0000; mref[12'h031] = 16'h8000; mref[12'h032] = 16'h1234;
        mref[12'h040] = 16'h4041; mref[12'h041] = 16'h3032;
        run_prog(2, 16'h000F, 12'h041);

        // program 3: I/O (R9), shifts (R10), PC wrap 0xFFF->0x000 (R2), patched word 0 (R8)
        clear_mem();
        io_q = '{16'h1234, 16'h0041};
        mref[12'h000] = 16'hC100;
        mref[12'h100] = 16'h1000; mref[12'h101] = 16'h2403; mref[12'h102] = 16'h2805;
        mref[12'h103] = 16'h2C04; mref[12'h104] = 16'h2001; mref[12'h105] = 16'h1800;
        mref[12'h106] = 16'h1C00; mref[12'h107] = 16'h1400; mref[12'h108] = 16'h3110;
        mref[12'h109] = 16'h4000; mref[12'h10A] = 16'hCFFF; mref[12'h110] = 16'h0007;
        mref[12'hFFF] = 16'hB000;
        printed = 16'h0;
        run_prog(3, 16'h0007, 12'h000);
        check("R9", "value presented to print", printed, 16'h0918);
        check("R9", "input queue consumed", 16'(io_q.size()), 16'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule